// File: doc/BRIEF.md
# Pipelined Multi-Mode Integer Multiplier

This block is the fixed-latency multiply unit of a 64-bit execute stage. The issuing stage hands it two 65-bit operands that it has already widened by one bit: a copy of bit 63 for a signed operation, or a zero for an unsigned one. Because of that extra bit, a single signed datapath gives correct products for signed and unsigned instructions alike, and the unit never has to know which kind it serves.

A 2-bit mode code picks the slice of the product to return: the low doubleword, the high doubleword, or the high half of a 32x32 product copied into both word positions. Each accepted request produces one result pulse a fixed number of cycles later, with a 64-bit value and an overflow flag. The issuing stage keeps the destination register, the record and overflow-enable bits and the status register, and it decides what to do with the flag. A new request may enter on every cycle.

Top module: `imul_pipe`

## Requirements
- R1: Both operands are treated as signed 65-bit two's-complement values. With bit 64 set to a copy of bit 63, the product is the signed product of the 64-bit values. With bit 64 set to zero, it is the unsigned product.
- R2: `res_vld` is high exactly `PIPE_DEPTH` (default 4) cycles after the cycle in which `req_vld` was sampled high.
- R3: `res_vld` pulses for one cycle for each accepted request and is low on every other cycle. While `res_vld` is low, `res_data` is all zeros and `res_ovf` is low.
- R4: Mode 0 (low doubleword) returns product bits 63:0. Mode code 3 is handled the same way as mode 0.
- R5: Mode 1 (high doubleword) returns product bits 127:64, and `res_ovf` is low.
- R6: Mode 2 (word high) returns product bits 63:32 in result bits 31:0 and again in result bits 63:32.
- R7: In mode 0 or mode 3, `res_ovf` is high when product bits 127:63 are not all equal. In mode 2, it is high when product bits 63:31 are not all equal.
- R8: A request is accepted on every cycle. Back-to-back requests in mixed modes return in issue order, and each result matches its own operands and mode.
- R9: While `rst_n` is low, `res_vld` is low. Requests that are in flight when reset is asserted never produce a result pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_vld | input | 1 | Request valid, sampled on each rising edge |
| req_mode | input | 2 | Mode: 0 low doubleword, 1 high doubleword, 2 word high, 3 as 0 |
| req_a | input | 65 | First operand, already extended to 65 bits by the caller |
| req_b | input | 65 | Second operand, already extended to 65 bits by the caller |
| res_vld | output | 1 | One-cycle result pulse |
| res_data | output | 64 | Selected product slice; zero when no result is due |
| res_ovf | output | 1 | Overflow flag for the returned slice |

## Verification
Each stage carries a valid bit, a mode code and the product. A valid bit lost or duplicated inside the pipe shows up at `res_vld` as a missing or extra pulse exactly `PIPE_DEPTH` cycles after the request. A mode code or product that drifts to a neighbouring stage corrupts `res_data` or `res_ovf` of that same pulse. Back-to-back requests in mixed modes and extensions expose any crosstalk between stages on the next result. A reset asserted with requests in flight shows any stale valid bit as a pulse after release.

// File: rtl/imul_pkg.sv
package imul_pkg;
  typedef enum logic [1:0] {
    IMUL_LO64 = 2'd0,
    IMUL_HI64 = 2'd1,
    IMUL_HI32 = 2'd2,
    IMUL_RSVD = 2'd3
  } imul_mode_e;
endpackage

// File: rtl/imul_rst_sync.sv
module imul_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/imul_mult.sv
module imul_mult #(
  parameter int OPW  = 65,
  parameter int PW   = 128
) (
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  output logic [PW-1:0]  prod
);
  localparam int EXTW = PW - OPW;

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  // The low PW bits of a wider signed product equal the low PW bits
  // of the product of the operands sign-extended to PW.
  always_comb begin
    a_ext = {{EXTW{op_a[OPW-1]}}, op_a};
    b_ext = {{EXTW{op_b[OPW-1]}}, op_b};
    prod  = a_ext * b_ext;
  end
endmodule

// File: rtl/imul_stage.sv
module imul_stage
  import imul_pkg::*;
#(
  parameter int PW = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vld_i,
  input  imul_mode_e mode_i,
  input  logic [PW-1:0] prod_i,
  output logic       vld_o,
  output imul_mode_e mode_o,
  output logic [PW-1:0] prod_o
);
  logic          vld_q;
  logic          vld_d;
  logic          load_en;
  imul_mode_e    mode_q;
  logic [PW-1:0] prod_q;

  always_comb begin
    vld_d   = vld_i;
    load_en = vld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // Payload flops load only with a live request; they carry no reset.
  always_ff @(posedge clk) begin
    if (load_en) begin
      mode_q <= mode_i;
      prod_q <= prod_i;
    end
  end

  assign vld_o  = vld_q;
  assign mode_o = mode_q;
  assign prod_o = prod_q;

  // R2: each stage moves a valid bit forward by exactly one cycle.
  assert_stage_step_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (vld_o == $past(vld_i)));

  // R8: a live request's mode code is carried without change.
  assert_mode_carry_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (mode_o == $past(mode_i)));
endmodule

// File: rtl/imul_select.sv
module imul_select
  import imul_pkg::*;
#(
  parameter int RW = 64
) (
  input  logic          vld,
  input  imul_mode_e    mode,
  input  logic [2*RW-1:0] prod,
  output logic [RW-1:0] res,
  output logic          ovf
);
  localparam int HW = RW / 2;

  logic [RW:0]   lo_sign;
  logic [HW:0]   wd_sign;
  logic          lo_ovf;
  logic          wd_ovf;

  always_comb begin
    lo_sign = prod[2*RW-1:RW-1];
    wd_sign = prod[RW-1:HW-1];
    lo_ovf  = !((&lo_sign) || (~|lo_sign));
    wd_ovf  = !((&wd_sign) || (~|wd_sign));
    res     = '0;
    ovf     = 1'b0;
    if (vld) begin
      unique case (mode)
        IMUL_HI64: begin
          res = prod[2*RW-1:RW];
          ovf = 1'b0;
        end
        IMUL_HI32: begin
          res = {prod[RW-1:HW], prod[RW-1:HW]};
          ovf = wd_ovf;
        end
        default: begin
          res = prod[RW-1:0];
          ovf = lo_ovf;
        end
      endcase
    end
  end
endmodule

// File: rtl/imul_pipe.sv
module imul_pipe
  import imul_pkg::*;
#(
  parameter int PIPE_DEPTH = 4,
  parameter int RES_W      = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic [1:0]       req_mode,
  input  logic [RES_W:0]   req_a,
  input  logic [RES_W:0]   req_b,
  output logic             res_vld,
  output logic [RES_W-1:0] res_data,
  output logic             res_ovf
);
  localparam int OPW = RES_W + 1;
  localparam int PW  = 2 * RES_W;

  logic          srst_n;
  logic          vld_s  [0:PIPE_DEPTH];
  imul_mode_e    mode_s [0:PIPE_DEPTH];
  logic [PW-1:0] prod_s [0:PIPE_DEPTH];

  imul_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  imul_mult #(.OPW(OPW), .PW(PW)) u_mult (
    .op_a (req_a),
    .op_b (req_b),
    .prod (prod_s[0])
  );

  always_comb begin
    vld_s[0]  = req_vld;
    mode_s[0] = imul_mode_e'(req_mode);
  end

  for (genvar g = 0; g < PIPE_DEPTH; g++) begin : g_stage
    imul_stage #(.PW(PW)) u_stage (
      .clk    (clk),
      .rst_n  (srst_n),
      .vld_i  (vld_s[g]),
      .mode_i (mode_s[g]),
      .prod_i (prod_s[g]),
      .vld_o  (vld_s[g+1]),
      .mode_o (mode_s[g+1]),
      .prod_o (prod_s[g+1])
    );
  end

  imul_select #(.RW(RES_W)) u_sel (
    .vld  (vld_s[PIPE_DEPTH]),
    .mode (mode_s[PIPE_DEPTH]),
    .prod (prod_s[PIPE_DEPTH]),
    .res  (res_data),
    .ovf  (res_ovf)
  );

  assign res_vld = vld_s[PIPE_DEPTH];

  // R9: the pipe is empty while the external reset is held.
  assert_reset_quiet_R9 : assert property (@(posedge clk)
    !rst_n |-> !res_vld);

  // R3: no result pulse leaves stray data or a stray flag.
  assert_idle_zero_R3 : assert property (@(posedge clk) disable iff (!srst_n)
    !res_vld |-> (res_data == '0 && !res_ovf));

  // R5: the high-doubleword slice never flags overflow.
  assert_no_overflow_R5 : assert property (@(posedge clk) disable iff (!srst_n)
    (res_vld && mode_s[PIPE_DEPTH] == IMUL_HI64) |-> !res_ovf);

  // R6: the word-high slice shows the same word in both halves.
  assert_word_mirror_R6 : assert property (@(posedge clk) disable iff (!srst_n)
    (res_vld && mode_s[PIPE_DEPTH] == IMUL_HI32)
      |-> (res_data[RES_W-1:RES_W/2] == res_data[RES_W/2-1:0]));
endmodule

// File: tb/imul_pipe_bench.sv
module imul_pipe_bench;
  localparam int D   = 4;
  localparam int RW  = 64;
  localparam int RING = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_vld;
  logic [1:0]    req_mode;
  logic [RW:0]   req_a;
  logic [RW:0]   req_b;
  logic          res_vld;
  logic [RW-1:0] res_data;
  logic          res_ovf;

  int n_vec  = 0;
  int n_bad  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic          ex_v   [RING];
  logic [RW-1:0] ex_res [RING];
  logic          ex_ovf [RING];
  string         ex_tag [RING];

  always #4 clk = ~clk;

  imul_pipe #(.PIPE_DEPTH(D), .RES_W(RW)) u_imul_pipe (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_mode(req_mode),
    .req_a(req_a), .req_b(req_b), .res_vld(res_vld),
    .res_data(res_data), .res_ovf(res_ovf)
  );

  // Reference: full signed product, slice and flag from the requirements.
  function automatic logic [RW:0] model(input logic [1:0] m,
                                        input logic [RW:0] a,
                                        input logic [RW:0] b);
    logic signed [2*RW-1:0] ax, bx, p;
    logic [RW-1:0] r;
    logic o;
    ax = {{(RW-1){a[RW]}}, a};
    bx = {{(RW-1){b[RW]}}, b};
    p  = ax * bx;
    case (m)
      2'd1: begin r = p[127:64]; o = 1'b0; end
      2'd2: begin
        r = {p[63:32], p[63:32]};
        o = !((&p[63:31]) || (~|p[63:31]));
      end
      default: begin
        r = p[63:0];
        o = !((&p[127:63]) || (~|p[127:63]));
      end
    endcase
    return {o, r};
  endfunction

  function automatic logic [RW:0] widen(input int kind, input logic [63:0] r);
    case (kind)
      0: return {1'b0, r};                 // unsigned doubleword
      1: return {r[63], r};                // signed doubleword
      2: return {{33{r[31]}}, r[31:0]};    // signed word
      3: return {33'd0, r[31:0]};          // unsigned word
      default: return {{49{r[15]}}, r[15:0]}; // signed 16-bit immediate
    endcase
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic check_out();
    int k;
    k = (cyc + RING - D) % RING;
    n_vec++;
    if (res_vld !== ex_v[k]) begin
      n_bad++;
      $display("FAIL %s res_vld actual %b expected %b (cycle %0d)",
               ex_v[k] ? ex_tag[k] : "R2", res_vld, ex_v[k], cyc);
    end else if (ex_v[k]) begin
      n_vec++;
      if (res_data !== ex_res[k]) begin
        n_bad++;
        $display("FAIL %s res_data actual %h expected %h", ex_tag[k], res_data, ex_res[k]);
      end
      n_vec++;
      if (res_ovf !== ex_ovf[k]) begin
        n_bad++;
        $display("FAIL R7 res_ovf actual %b expected %b (data %h)", res_ovf, ex_ovf[k], res_data);
      end
    end else begin
      n_vec++;
      if (res_data !== '0 || res_ovf !== 1'b0) begin
        n_bad++;
        $display("FAIL R3 idle outputs actual %h/%b expected 0/0", res_data, res_ovf);
      end
    end
  endtask

  task automatic step(input logic v, input logic [1:0] m,
                      input logic [RW:0] a, input logic [RW:0] b,
                      input string tg, input logic rl);
    logic [RW:0] e;
    int k;
    @(negedge clk);
    check_out();
    rst_n = rl;
    if (!rl) begin
      for (int i = 0; i < RING; i++) begin ex_v[i] = 1'b0; ex_tag[i] = "R9"; end
    end
    req_vld = v; req_mode = m; req_a = a; req_b = b;
    k = cyc % RING;
    e = model(m, a, b);
    ex_v[k]   = v && rl;
    ex_res[k] = e[RW-1:0];
    ex_ovf[k] = e[RW];
    ex_tag[k] = (tg == "") ? mode_tag(m) : tg;
    cyc++;
  endtask

  task automatic idle(input int n, input logic rl);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, '0, "R3", rl);
  endtask

  task automatic req(input logic [1:0] m, input logic [RW:0] a,
                     input logic [RW:0] b, input string tg);
    step(1'b1, m, a, b, tg, 1'b1);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  initial begin
    logic [63:0] r1, r2;
    int mk, ka, kb;
    rst_n = 1'b0; req_vld = 1'b0; req_mode = '0; req_a = '0; req_b = '0;
    for (int i = 0; i < RING; i++) begin
      ex_v[i] = 1'b0; ex_res[i] = '0; ex_ovf[i] = 1'b0; ex_tag[i] = "R9";
    end
    void'($urandom(32'd2024));

    // R9: reset state, held with a request presented.
    step(1'b1, 2'd0, 65'd3, 65'd5, "R9", 1'b0);
    idle(3, 1'b0);
    idle(4, 1'b1);

    // R2: one isolated request, then silence.
    req(2'd0, 65'h1000, 65'h1111, "R2");
    idle(D + 2, 1'b1);
    req(2'd0, 65'h1000, 65'h1111, "R4");
    idle(2, 1'b1);

    // Directed corners: R1 R4 R5 R6 R7.
    req(2'd0, {1'b1, 64'h8000_0000_0000_0000}, {1'b1, 64'h8000_0000_0000_0000}, "R7");
    req(2'd1, {1'b1, 64'h8000_0000_0000_0000}, {1'b1, 64'h8000_0000_0000_0000}, "R5");
    req(2'd1, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF}, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF}, "R1");
    req(2'd1, {1'b1, 64'hFFFF_FFFF_FFFF_FFFF}, {1'b1, 64'hFFFF_FFFF_FFFF_FFFF}, "R1");
    req(2'd0, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF}, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF}, "R7");
    req(2'd2, widen(2, 64'h8000_0000), widen(2, 64'h8000_0000), "R6");
    req(2'd2, widen(3, 64'hFFFF_FFFF), widen(3, 64'hFFFF_FFFF), "R6");
    req(2'd2, widen(2, 64'h0000_1234), widen(2, 64'h0000_0010), "R6");
    req(2'd3, widen(1, 64'h7FFF_FFFF_FFFF_FFFF), widen(4, 64'h0000_FFFE), "R4");
    req(2'd0, widen(1, 64'h4000_0000_0000_0000), widen(4, 64'h0000_0002), "R7");
    idle(D + 1, 1'b1);

    // R8: back-to-back mixed modes.
    for (int i = 0; i < 24; i++) begin
      r1 = {$urandom(), $urandom()}; r2 = {$urandom(), $urandom()};
      mk = i % 3;
      ka = (mk == 2) ? 2 + (i & 1) : (i & 1);
      req(2'(mk), widen(ka, r1), widen(ka, r2), "R8");
    end

    // R9: reset with results in flight, then nothing must emerge.
    req(2'd0, widen(1, 64'd7), widen(1, 64'd9), "R9");
    req(2'd1, widen(0, 64'd7), widen(0, 64'd9), "R9");
    step(1'b0, 2'd0, '0, '0, "R9", 1'b0);
    idle(2, 1'b0);
    idle(D + 3, 1'b1);

    // Constrained random traffic with gaps.
    for (int i = 0; i < 3000; i++) begin
      r1 = {$urandom(), $urandom()}; r2 = {$urandom(), $urandom()};
      mk = $urandom_range(0, 3);
      case (mk)
        1: begin ka = $urandom_range(0, 1); kb = ka; end
        2: begin ka = $urandom_range(2, 3); kb = ka; end
        default: begin ka = $urandom_range(0, 4); kb = $urandom_range(1, 4);
                       if (ka == 0) kb = 0; end
      endcase
      step(($urandom_range(0, 3) != 0), 2'(mk), widen(ka, r1), widen(kb, r2), "", 1'b1);
    end
    idle(D + 2, 1'b1);

    done = 1;
    summary();
  end
endmodule